// File: doc/BRIEF.md
# Packed SIMD Integer ALU

The block is a 64-bit packed integer arithmetic and logic unit. Each cycle it takes two 64-bit sources and treats them either as eight unsigned byte lanes or as four signed halfword lanes. The first source is always used lane by lane. The second source can be used lane by lane, as one of its lanes copied to every lane, or replaced by a small immediate copied to every lane. A 4-bit operation code selects a logic, shift, saturating arithmetic, min/max or special lane function. The special functions depend on the format.

Alongside the 64-bit result, the unit produces one condition bit per lane. These bits come from an equal and/or less-than test on the same lane pair that feeds the ALU. Operation codes that have no meaning for the chosen format are flagged and give a zero result. By default the outputs are registered, so they appear one clock after the inputs. A parameter can make the unit purely combinational.

Top module: `packed_simd_alu`

## Requirements
- R1: `fmt_sel[0]` = 0 selects eight unsigned 8-bit lanes and `fmt_sel[0]` = 1 selects four signed 16-bit lanes. Lane 0 occupies the least significant bits of every vector.
- R2: `fmt_sel[4:3]` chooses the second operand. 2'b10 uses `src_b` lane by lane. 2'b11 uses `imm`, zero-extended to the lane width and copied to every lane. Any value with `fmt_sel[4]` = 0 copies one lane of `src_b` to every lane.
- R3: When a lane is copied, the halfword lane index is `fmt_sel[3:2]` and the byte lane index is `fmt_sel[3:1]`.
- R4: Codes 0, 1, 2 and 3 give bitwise AND, NOR, OR and XOR of each lane pair.
- R5: Code 4 shifts left logically, code 5 shifts right logically and code 12 (halfword only) shifts right arithmetically. The shift count is the low 4 bits of the second lane for halfwords and the low 3 bits for bytes.
- R6: Codes 6 (add), 7 (subtract) and 10 (multiply) saturate. Byte results clamp to 0..255 and halfword results clamp to -32768..32767.
- R7: Codes 8 and 9 give the minimum and maximum of each lane pair. The comparison is signed for halfwords and unsigned for bytes.
- R8: Code 11 (halfword only) returns the second lane when the first lane is non-negative, and its negation when the first lane is negative. Negating -32768 gives 32767.
- R9: Code 13 (byte only) returns |a-b|. Code 14 (byte only) returns (a+b+1)>>1 computed without overflow.
- R10: `cond[i]` is 1 when (`cmp_eq` and lane a = lane b) or (`cmp_lt` and lane a < lane b). The test is signed for halfwords and unsigned for bytes. In halfword format `cond[7:4]` is 0.
- R11: `illegal` is 1 and `result` is 0 for codes 11, 12 and 15 in byte format, and for codes 13, 14 and 15 in halfword format.
- R12: With registered outputs, `result`, `cond` and `illegal` reflect the inputs sampled at the previous rising clock edge. An active-low reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 64 | First operand vector |
| src_b | input | 64 | Second operand vector, or the source of the copied lane |
| imm | input | 5 | Immediate second operand |
| fmt_sel | input | 5 | Lane format (bit 0), operand source and lane index |
| opcode | input | 4 | Lane operation code |
| cmp_eq | input | 1 | Request the equality term in the condition bits |
| cmp_lt | input | 1 | Request the less-than term in the condition bits |
| result | output | 64 | Packed lane result |
| cond | output | 8 | Per-lane condition bits |
| illegal | output | 1 | Operation code is undefined for the selected format |

## Verification
The ALU result and the condition bits are computed in the same cycle from the same operand pair. The bench therefore drives compare requests together with every arithmetic and logic operation, including saturating and illegal codes, and through all three second-operand sources. A scoreboard item checks the result word, the condition byte and the illegal flag together, one clock after the inputs are driven. A mistake in lane selection or signedness therefore shows up in both outputs of the same cycle. A randomized sweep with a behavioural integer model covers the remaining mixes.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
   localparam int OB_W = 8;
   localparam int QH_W = 16;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_NOR = 4'd1,  OP_OR  = 4'd2,  OP_XOR = 4'd3,
      OP_SLL = 4'd4,  OP_SRL = 4'd5,  OP_ADD = 4'd6,  OP_SUB = 4'd7,
      OP_MIN = 4'd8,  OP_MAX = 4'd9,  OP_MUL = 4'd10, OP_SGN = 4'd11,
      OP_SRA = 4'd12, OP_ABD = 4'd13, OP_AVG = 4'd14, OP_RSV = 4'd15
   } lane_op_e;

   typedef enum logic [1:0] {
      SRC_ELEM = 2'd0,
      SRC_VEC  = 2'd1,
      SRC_IMM  = 2'd2
   } b_src_e;

   // mode bits are fmt_sel[4:3]
   function automatic b_src_e src_decode(input logic [1:0] mode_bits);
      if (!mode_bits[1])     return SRC_ELEM;
      else if (!mode_bits[0]) return SRC_VEC;
      else                    return SRC_IMM;
   endfunction
endpackage

// File: rtl/psimd_operand_mux.sv
module psimd_operand_mux
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 5
) (
   input  logic [DATA_W-1:0] vec_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [3:0]        sel_hi,   // fmt_sel[4:1]
   output logic [DATA_W-1:0] b_ob,
   output logic [DATA_W-1:0] b_qh
);
   localparam int NB = DATA_W / OB_W;
   localparam int NH = DATA_W / QH_W;

   b_src_e          mode;
   logic [OB_W-1:0] ob_elem;
   logic [OB_W-1:0] ob_imm;
   logic [QH_W-1:0] qh_elem;
   logic [QH_W-1:0] qh_imm;

   always_comb begin
      mode    = src_decode(sel_hi[3:2]);
      ob_elem = vec_b[int'(sel_hi[2:0]) * OB_W +: OB_W];
      qh_elem = vec_b[int'(sel_hi[2:1]) * QH_W +: QH_W];
      ob_imm  = OB_W'(imm);
      qh_imm  = QH_W'(imm);
   end

   for (genvar i = 0; i < NB; i++) begin : g_ob
      assign b_ob[i*OB_W +: OB_W] = (mode == SRC_VEC) ? vec_b[i*OB_W +: OB_W] :
                                    (mode == SRC_IMM) ? ob_imm : ob_elem;
   end

   for (genvar i = 0; i < NH; i++) begin : g_qh
      assign b_qh[i*QH_W +: QH_W] = (mode == SRC_VEC) ? vec_b[i*QH_W +: QH_W] :
                                    (mode == SRC_IMM) ? qh_imm : qh_elem;
   end
endmodule

// File: rtl/psimd_ob_lane.sv
module psimd_ob_lane
   import psimd_pkg::*;
#(
   parameter int W = OB_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  lane_op_e     op,
   input  logic         eq_req,
   input  logic         lt_req,
   output logic [W-1:0] y,
   output logic         hit,
   output logic         bad
);
   localparam int SH_W = $clog2(W);

   logic [W:0]     sum;
   logic [W:0]     dif;
   logic [2*W-1:0] prod;

   always_comb begin
      sum  = {1'b0, a} + {1'b0, b};
      dif  = {1'b0, a} - {1'b0, b};
      prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      y    = '0;
      bad  = 1'b0;
      case (op)
         OP_AND: y = a & b;
         OP_NOR: y = ~(a | b);
         OP_OR:  y = a | b;
         OP_XOR: y = a ^ b;
         OP_SLL: y = a << b[SH_W-1:0];
         OP_SRL: y = a >> b[SH_W-1:0];
         OP_ADD: y = sum[W] ? '1 : sum[W-1:0];
         OP_SUB: y = dif[W] ? '0 : dif[W-1:0];
         OP_MIN: y = (a < b) ? a : b;
         OP_MAX: y = (a > b) ? a : b;
         OP_MUL: y = (|prod[2*W-1:W]) ? '1 : prod[W-1:0];
         OP_ABD: y = (a >= b) ? (a - b) : (b - a);
         OP_AVG: y = W'((sum + (W+1)'(1)) >> 1);
         default: bad = 1'b1;
      endcase
      hit = (eq_req && (a == b)) || (lt_req && (a < b));
   end
endmodule

// File: rtl/psimd_qh_lane.sv
module psimd_qh_lane
   import psimd_pkg::*;
#(
   parameter int W = QH_W
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  lane_op_e     op,
   input  logic         eq_req,
   input  logic         lt_req,
   output logic [W-1:0] y,
   output logic         hit,
   output logic         bad
);
   localparam int          SH_W = $clog2(W);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic signed [W-1:0]   sa;
   logic signed [W-1:0]   sb;
   logic        [W:0]     s_sum;
   logic        [W:0]     s_dif;
   logic signed [2*W-1:0] s_prod;
   logic        [W-1:0]   neg_b;
   logic                  prod_ovf;

   always_comb begin
      sa       = $signed(a);
      sb       = $signed(b);
      s_sum    = {a[W-1], a} + {b[W-1], b};
      s_dif    = {a[W-1], a} - {b[W-1], b};
      s_prod   = sa * sb;
      prod_ovf = !((&s_prod[2*W-1:W-1]) || !(|s_prod[2*W-1:W-1]));
      neg_b    = (b == SMIN) ? SMAX : (~b + 1'b1);
      y        = '0;
      bad      = 1'b0;
      case (op)
         OP_AND: y = a & b;
         OP_NOR: y = ~(a | b);
         OP_OR:  y = a | b;
         OP_XOR: y = a ^ b;
         OP_SLL: y = a << b[SH_W-1:0];
         OP_SRL: y = a >> b[SH_W-1:0];
         OP_SRA: y = sa >>> b[SH_W-1:0];
         OP_ADD: y = (s_sum[W] != s_sum[W-1]) ? (s_sum[W] ? SMIN : SMAX) : s_sum[W-1:0];
         OP_SUB: y = (s_dif[W] != s_dif[W-1]) ? (s_dif[W] ? SMIN : SMAX) : s_dif[W-1:0];
         OP_MIN: y = (sa < sb) ? a : b;
         OP_MAX: y = (sa > sb) ? a : b;
         OP_MUL: y = prod_ovf ? (s_prod[2*W-1] ? SMIN : SMAX) : s_prod[W-1:0];
         OP_SGN: y = a[W-1] ? neg_b : b;
         default: bad = 1'b1;
      endcase
      hit = (eq_req && (a == b)) || (lt_req && (sa < sb));
   end
endmodule

// File: rtl/packed_simd_alu.sv
module packed_simd_alu
   import psimd_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int IMM_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DATA_W-1:0]        src_a,
   input  logic [DATA_W-1:0]        src_b,
   input  logic [IMM_W-1:0]         imm,
   input  logic [4:0]               fmt_sel,
   input  logic [3:0]               opcode,
   input  logic                     cmp_eq,
   input  logic                     cmp_lt,
   output logic [DATA_W-1:0]        result,
   output logic [DATA_W/OB_W-1:0]   cond,
   output logic                     illegal
);
   localparam int NB = DATA_W / OB_W;
   localparam int NH = DATA_W / QH_W;

   if (DATA_W != 64) begin : g_bad_width
      $error("packed_simd_alu: lane index fields fix DATA_W at 64");
   end
   if (IMM_W > OB_W) begin : g_bad_imm
      $error("packed_simd_alu: immediate wider than a byte lane");
   end

   lane_op_e          op_e;
   logic [DATA_W-1:0] b_ob, b_qh;
   logic [DATA_W-1:0] ob_y, qh_y;
   logic [NB-1:0]     ob_hit, ob_bad;
   logic [NH-1:0]     qh_hit, qh_bad;
   logic [DATA_W-1:0] nxt_res;
   logic [NB-1:0]     nxt_cond;
   logic              nxt_ill;

   assign op_e = lane_op_e'(opcode);

   psimd_operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bmux (
      .vec_b  (src_b),
      .imm    (imm),
      .sel_hi (fmt_sel[4:1]),
      .b_ob   (b_ob),
      .b_qh   (b_qh)
   );

   for (genvar i = 0; i < NB; i++) begin : g_ob_lane
      psimd_ob_lane #(.W(OB_W)) u_lane (
         .a      (src_a[i*OB_W +: OB_W]),
         .b      (b_ob[i*OB_W +: OB_W]),
         .op     (op_e),
         .eq_req (cmp_eq),
         .lt_req (cmp_lt),
         .y      (ob_y[i*OB_W +: OB_W]),
         .hit    (ob_hit[i]),
         .bad    (ob_bad[i])
      );
   end

   for (genvar i = 0; i < NH; i++) begin : g_qh_lane
      psimd_qh_lane #(.W(QH_W)) u_lane (
         .a      (src_a[i*QH_W +: QH_W]),
         .b      (b_qh[i*QH_W +: QH_W]),
         .op     (op_e),
         .eq_req (cmp_eq),
         .lt_req (cmp_lt),
         .y      (qh_y[i*QH_W +: QH_W]),
         .hit    (qh_hit[i]),
         .bad    (qh_bad[i])
      );
   end

   always_comb begin
      if (fmt_sel[0]) begin
         nxt_res  = qh_y;
         nxt_cond = NB'(qh_hit);
         nxt_ill  = |qh_bad;
      end else begin
         nxt_res  = ob_y;
         nxt_cond = ob_hit;
         nxt_ill  = |ob_bad;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result  <= '0;
            cond    <= '0;
            illegal <= 1'b0;
         end else begin
            result  <= nxt_res;
            cond    <= nxt_cond;
            illegal <= nxt_ill;
         end
      end
   end else begin : g_comb_out
      assign result  = nxt_res;
      assign cond    = nxt_cond;
      assign illegal = nxt_ill;
   end
endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk #(
   parameter int DATA_W  = 64,
   parameter int NB      = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [4:0]        fmt_sel,
   input logic [3:0]        opcode,
   input logic              cmp_eq,
   input logic [DATA_W-1:0] result,
   input logic [NB-1:0]     cond,
   input logic              illegal
);
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == '0)); // R11

   if (REG_OUT) begin : g_seq
      AST_QH_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_sel[0] && (opcode > 4'd12)) |=> illegal); // R11

      AST_OB_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
         (!fmt_sel[0] && ((opcode == 4'd11) || (opcode == 4'd12) || (opcode == 4'd15)))
         |=> illegal); // R11

      AST_AND_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
         ((opcode == 4'd0) && (fmt_sel[4:3] == 2'b10)) |=> (result == $past(src_a & src_b))); // R4

      AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         ((opcode == 4'd3) && (fmt_sel[4:3] == 2'b10) && (src_a == src_b)) |=> (result == '0)); // R4

      AST_QH_COND_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
         fmt_sel[0] |=> (cond[NB-1:NB/2] == '0)); // R10

      AST_EQ_SELF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_eq && (fmt_sel[4:3] == 2'b10) && (src_a == src_b)) |=> (cond[NB/2-1:0] == '1)); // R10
   end
endmodule

bind packed_simd_alu psimd_alu_chk #(
   .DATA_W  (DATA_W),
   .NB      (DATA_W / 8),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_a   (src_a),
   .src_b   (src_b),
   .fmt_sel (fmt_sel),
   .opcode  (opcode),
   .cmp_eq  (cmp_eq),
   .result  (result),
   .cond    (cond),
   .illegal (illegal)
);

// File: tb/packed_simd_alu_tb.sv
module packed_simd_alu_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_a = '0, src_b = '0;
   logic [4:0]  imm = '0, fmt_sel = '0;
   logic [3:0]  opcode = '0;
   logic        cmp_eq = 1'b0, cmp_lt = 1'b0;
   logic [63:0] result;
   logic [7:0]  cond;
   logic        illegal;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [63:0] r;
      logic [7:0]  c;
      logic        ill;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_P/2) clk = ~clk;

   packed_simd_alu u_dut (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .imm(imm),
      .fmt_sel(fmt_sel), .opcode(opcode), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt),
      .result(result), .cond(cond), .illegal(illegal)
   );

   // integer reference model written from the requirements
   function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [4:0] im, input logic [4:0] sl,
                                 input logic [3:0] op, input logic eq, input logic lt,
                                 output logic [63:0] r, output logic [7:0] c,
                                 output logic ill);
      bit qh = sl[0];
      int nl = qh ? 4 : 8;
      r = '0;
      c = '0;
      ill = qh ? (op >= 4'd13) : (op == 4'd11 || op == 4'd12 || op == 4'd15);
      for (int i = 0; i < nl; i++) begin
         int k, ux, uy, x, y, z, sh;
         if (!sl[4]) k = qh ? int'(sl[3:2]) : int'(sl[3:1]);
         else        k = i;
         ux = qh ? int'(a[i*16 +: 16]) : int'(a[i*8 +: 8]);
         if (sl[4:3] == 2'b11) uy = int'(im);
         else uy = qh ? int'(b[k*16 +: 16]) : int'(b[k*8 +: 8]);
         x  = (qh && ux >= 32768) ? ux - 65536 : ux;
         y  = (qh && uy >= 32768) ? uy - 65536 : uy;
         sh = qh ? (uy & 15) : (uy & 7);
         case (op)
            4'd0:  z = ux & uy;
            4'd1:  z = ~(ux | uy);
            4'd2:  z = ux | uy;
            4'd3:  z = ux ^ uy;
            4'd4:  z = ux << sh;
            4'd5:  z = ux >> sh;
            4'd6:  z = x + y;
            4'd7:  z = x - y;
            4'd8:  z = (x < y) ? x : y;
            4'd9:  z = (x > y) ? x : y;
            4'd10: z = x * y;
            4'd11: z = (x < 0) ? -y : y;
            4'd12: z = x >>> sh;
            4'd13: z = (x > y) ? x - y : y - x;
            4'd14: z = (x + y + 1) / 2;
            default: z = 0;
         endcase
         if (op == 4'd6 || op == 4'd7 || op == 4'd10 || op == 4'd11) begin
            int lo = qh ? -32768 : 0;
            int hi = qh ? 32767 : 255;
            if (z < lo) z = lo;
            if (z > hi) z = hi;
         end
         if (ill) z = 0;
         if (qh) r[i*16 +: 16] = 16'(z);
         else    r[i*8 +: 8]   = 8'(z);
         c[i] = (eq && x == y) || (lt && x < y);
      end
   endfunction

   task automatic go(input logic [63:0] a, input logic [63:0] b, input logic [4:0] im,
                     input logic [4:0] sl, input logic [3:0] op, input logic eq,
                     input logic lt, input string tag);
      exp_t e;
      @(negedge clk);
      src_a = a; src_b = b; imm = im; fmt_sel = sl; opcode = op;
      cmp_eq = eq; cmp_lt = lt;
      model(a, b, im, sl, op, eq, lt, e.r, e.c, e.ill);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: result of the item driven at the previous falling edge
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if (result !== e.r || cond !== e.c || illegal !== e.ill) begin
            n_fail++;
            $display("FAIL %s: got res=%h cond=%h ill=%b exp res=%h cond=%h ill=%b",
                     e.tag, result, cond, illegal, e.r, e.c, e.ill);
         end
      end
   end

   localparam logic [4:0] OB_VEC = 5'b10000, QH_VEC = 5'b10001;
   localparam logic [4:0] OB_IMM = 5'b11000, QH_IMM = 5'b11001;

   initial begin
      repeat (3) @(negedge clk);
      n_checks++; // R12 reset clears outputs
      if (result !== '0 || cond !== '0 || illegal !== 1'b0) begin
         n_fail++;
         $display("FAIL R12 reset: got res=%h cond=%h ill=%b exp 0", result, cond, illegal);
      end
      rst_n = 1'b1;

      go(64'hF0F0_3C3C_AA55_00FF, 64'hFF00_0F0F_5555_F0F0, 0, OB_VEC, 4'd0, 0, 0, "R4 R1 and bytes");
      go(64'h1234_8000_FFFF_0001, 64'h00FF_0001_0F0F_8000, 0, QH_VEC, 4'd1, 0, 0, "R4 nor halves");
      go(64'h0102_0408_1020_4080, 64'h8040_2010_0804_0201, 0, OB_VEC, 4'd2, 1, 1, "R4 R10 or with compare");
      go(64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 0, QH_VEC, 4'd3, 1, 0, "R4 R10 xor self");
      go(64'h0011_2233_4455_6677, 64'h0, 5'd31, OB_IMM, 4'd6, 0, 1, "R2 R6 imm add bytes");
      go(64'h0005_8000_0010_7FF0, 64'h0, 5'd20, QH_IMM, 4'd7, 1, 1, "R2 R6 imm sub halves");
      go(64'hF8F0_2010_0805_0100, 64'h0A0B_0C0D_0E0F_1011, 0, 5'b01010, 4'd9, 0, 1, "R3 max byte lane5");
      go(64'h8000_0005_FFFB_7FFF, 64'h1111_FFFC_2222_3333, 0, 5'b01001, 4'd8, 0, 1, "R3 R7 min half lane2");
      go(64'h8181_8181_8181_8181, 64'h0B0A_0908_0302_0100, 0, OB_VEC, 4'd4, 0, 0, "R5 sll bytes count low3");
      go(64'h8000_F00F_1234_FFFF, 64'h0013_0004_000F_0001, 0, QH_VEC, 4'd5, 0, 0, "R5 srl halves");
      go(64'h8000_F00F_1234_FFFF, 64'h0013_0004_000F_0001, 0, QH_VEC, 4'd12, 0, 0, "R5 sra halves");
      go(64'hC864_0A00_FF80_0102, 64'h64C8_1414_01FF_0201, 0, OB_VEC, 4'd6, 0, 0, "R6 add byte sat");
      go(64'h0A64_0000_FF80_0102, 64'h1414_0101_01FF_0201, 0, OB_VEC, 4'd7, 0, 0, "R6 sub byte floor");
      go(64'h7530_8AD0_0064_FFFF, 64'h2710_D8F0_0064_FFFF, 0, QH_VEC, 4'd6, 0, 0, "R6 add half sat");
      go(64'h7530_8AD0_0064_FFFF, 64'hD8F0_2710_0064_0001, 0, QH_VEC, 4'd7, 0, 0, "R6 sub half sat");
      go(64'h1410_FF02_100F_0301, 64'h1410_FF80_1011_0302, 0, OB_VEC, 4'd10, 0, 0, "R6 mul byte sat");
      go(64'h012C_FED4_0010_FFFF, 64'h012C_012C_0010_8000, 0, QH_VEC, 4'd10, 0, 0, "R6 mul half sat");
      go(64'h8001_0001_8000_0000, 64'h01FF_0001_FF00_0080, 0, OB_VEC, 4'd8, 1, 1, "R7 min unsigned bytes");
      go(64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_7FFF_8000, 0, QH_VEC, 4'd9, 0, 1, "R7 R10 max signed halves");
      go(64'hFFFF_0000_8000_0005, 64'h8000_8000_0003_FFFE, 0, QH_VEC, 4'd11, 0, 0, "R8 sign transfer");
      go(64'h0510_FF00_8040_0000, 64'h1005_00FF_4080_0000, 0, OB_VEC, 4'd13, 1, 0, "R9 absdiff");
      go(64'hFF01_FE00_0302_FFFF, 64'hFF02_0100_0403_FFFE, 0, OB_VEC, 4'd14, 0, 1, "R9 avg");
      go(64'h1, 64'h2, 0, OB_VEC, 4'd11, 1, 0, "R11 sgn on bytes");
      go(64'h1, 64'h2, 0, OB_VEC, 4'd12, 0, 1, "R11 sra on bytes");
      go(64'h1, 64'h2, 0, OB_VEC, 4'd15, 1, 1, "R11 code15 bytes");
      go(64'h5, 64'h5, 0, QH_VEC, 4'd13, 1, 0, "R11 absdiff on halves");
      go(64'h5, 64'h5, 0, QH_VEC, 4'd14, 0, 0, "R11 avg on halves");
      go(64'h5, 64'h5, 0, QH_IMM, 4'd15, 0, 1, "R11 code15 halves");
      go(64'h0000_FFFF_0001_8000, 64'h0, 5'd1, QH_IMM, 4'd8, 1, 1, "R10 R2 imm compare halves");

      for (int n = 0; n < 400; n++) begin
         logic [63:0] ra, rb;
         logic [4:0]  ri, rs;
         logic [3:0]  ro;
         ra = {$urandom, $urandom};
         rb = (n % 5 == 0) ? ra : {$urandom, $urandom};
         ri = 5'($urandom);
         rs = 5'($urandom);
         ro = 4'($urandom);
         go(ra, rb, ri, rs, ro, 1'($urandom), 1'($urandom), "R1 R2 R3 R12 random sweep");
      end

      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R12 scoreboard: got %0d pending exp 0", sb_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL R12 watchdog: got hung run exp completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule